// File: doc/BRIEF.md
# Linked Descriptor Scatter-Gather DMA Walker

This block walks a chain of 64-bit descriptors held in memory and turns each one into work on the data path of an SD host. A start strobe hands it the address of the first descriptor and the total number of bytes the data phase expects, which is block size times block count. The walker then fetches descriptors one at a time through a read port. For each descriptor it skips the entry, issues a run of word beats covering a memory region, or jumps to another table. It finishes on the descriptor that carries the end attribute.

Each beat moves four bytes. The address of every beat is presented on a request/acknowledge handshake toward the card data path, and that path moves the data in either direction. On a bad descriptor or a byte-count disagreement the walker raises a flag. It also reports the engine phase in which the fault was seen.

Top module: `sg_desc_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `dsc_req`, `beat_req`, `done`, `irq`, `err_len` and `err_desc` are 0, and `err_state` is 0.
- R2: A `start` pulse while idle fetches the first descriptor at `table_base`. A descriptor is 64 bits: address in bits 63:32, byte length in bits 31:16, attributes in bits 5:0. Unless a descriptor links elsewhere, the next descriptor is fetched at the current descriptor address plus 8. `dsc_req` and `dsc_addr` are held until `dsc_ack`.
- R3: The action code is {bit5, bit4}. Code 00 (no operation) and code 01 (reserved) are both skipped without any beat.
- R4: Action code 10 (transfer) issues length/4 beats at the descriptor address, addr+4, addr+8 and so on. Each beat is held until `beat_ack`. A length of 0 completes the descriptor at once with no beat. The largest legal length is 0xFFFC.
- R5: Action code 11 (link) makes the next fetch use the descriptor's address field.
- R6: Once a descriptor with attribute bit 1 (end) completes, `done` pulses for exactly one cycle and `busy` falls in that same cycle. End takes priority over a link.
- R7: When a descriptor with attribute bit 2 (interrupt) completes, `irq` pulses for one cycle. A transfer completes when its last beat is accepted. Any other descriptor completes when it is decoded.
- R8: A descriptor with attribute bit 0 (valid) clear sets `err_desc` and stops the walker without `done` or `irq`, with `err_state` = 1 (fetching descriptor).
- R9: A transfer or link address that is not a multiple of 4, or a transfer length that is not a multiple of 4, sets `err_desc` and stops the walker before any beat of that descriptor, with `err_state` = 2 (changing address).
- R10: When the chain ends, `err_len` is set if the sum of all transfer lengths differs from `expect_bytes`. `done` still pulses. `err_state` is 3 if the final descriptor was a transfer and 2 otherwise.
- R11: A `start` pulse while busy is ignored and does not change the walk in progress.
- R12: A new `start` clears `err_len`, `err_desc` and `err_state` (0 = stopped) before the new walk begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (idle only) |
| table_base | input | ADDR_W | Address of first descriptor |
| expect_bytes | input | CNT_W | Bytes the data phase expects |
| dsc_req | output | 1 | Descriptor read request |
| dsc_addr | output | ADDR_W | Descriptor read address |
| dsc_ack | input | 1 | Descriptor read accepted, data valid |
| dsc_data | input | 64 | Descriptor read data |
| beat_req | output | 1 | Four-byte beat request to data path |
| beat_addr | output | ADDR_W | Memory address of the beat |
| beat_ack | input | 1 | Beat accepted |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at end of chain |
| irq | output | 1 | One-cycle pulse on interrupt descriptor completion |
| err_len | output | 1 | Length mismatch flag |
| err_desc | output | 1 | Bad descriptor flag |
| err_state | output | 2 | Engine phase at error: 0 stopped, 1 fetch, 2 change address, 3 transfer |

## Verification
The first fetch request appears one cycle after `start` is taken. A decode cycle separates every accepted fetch from the next action. A beat request follows the decode directly, and `irq` and `done` rise in the cycle after the handshake or decode that completes their descriptor. The bench drives acknowledges on falling edges with random stalls. It compares every accepted fetch address and beat address against queues produced by a behavioural walk of the same memory image. Each `irq` and `done` pulse is checked against the number of handshakes that must precede it. The error flags and phase code are compared once `busy` has fallen.

// File: rtl/sg_desc_walker.sv
module sg_desc_walker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] table_base,
  input  logic [CNT_W-1:0]  expect_bytes,
  output logic              dsc_req,
  output logic [ADDR_W-1:0] dsc_addr,
  input  logic              dsc_ack,
  input  logic [63:0]       dsc_data,
  output logic              beat_req,
  output logic [ADDR_W-1:0] beat_addr,
  input  logic              beat_ack,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic              err_len,
  output logic              err_desc,
  output logic [1:0]        err_state
);

  localparam int LEN_W = 16;
  localparam logic [ADDR_W-1:0] DSC_STEP = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] BEAT_STEP = ADDR_W'(4);
  localparam logic [LEN_W-1:0] LAST_BEAT = LEN_W'(4);

  typedef enum logic [1:0] {
    PH_STOP  = 2'd0,
    PH_FETCH = 2'd1,
    PH_ADDR  = 2'd2,
    PH_MOVE  = 2'd3
  } phase_t;

  phase_t            ph;
  logic [63:0]       cur;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] wptr;
  logic [LEN_W-1:0]  left;
  logic [CNT_W-1:0]  sum;
  logic [CNT_W-1:0]  want;

  wire              f_valid = cur[0];
  wire              f_end   = cur[1];
  wire              f_int   = cur[2];
  wire [1:0]        f_act   = cur[5:4];
  wire [LEN_W-1:0]  f_len   = cur[31:16];
  wire [ADDR_W-1:0] f_addr  = cur[32 +: ADDR_W];

  wire is_move = (f_act == 2'b10);
  wire is_link = (f_act == 2'b11);
  wire addr_bad = (f_addr[1:0] != 2'b00);
  wire len_bad  = (f_len[1:0] != 2'b00);
  wire shape_bad = (is_link && addr_bad) || (is_move && (addr_bad || len_bad));
  wire [CNT_W-1:0] sum_nx = sum + (is_move ? CNT_W'(f_len) : '0);

  assign busy      = (ph != PH_STOP);
  assign dsc_req   = (ph == PH_FETCH);
  assign dsc_addr  = ptr;
  assign beat_req  = (ph == PH_MOVE);
  assign beat_addr = wptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_STOP;
      cur       <= '0;
      ptr       <= '0;
      wptr      <= '0;
      left      <= '0;
      sum       <= '0;
      want      <= '0;
      done      <= 1'b0;
      irq       <= 1'b0;
      err_len   <= 1'b0;
      err_desc  <= 1'b0;
      err_state <= 2'd0;
    end else begin
      done <= 1'b0;
      irq  <= 1'b0;
      case (ph)
        PH_STOP: begin
          if (start) begin
            ptr       <= table_base;
            want      <= expect_bytes;
            sum       <= '0;
            err_len   <= 1'b0;
            err_desc  <= 1'b0;
            err_state <= 2'd0;
            ph        <= PH_FETCH;
          end
        end
        PH_FETCH: begin
          if (dsc_ack) begin
            cur <= dsc_data;
            ph  <= PH_ADDR;
          end
        end
        PH_ADDR: begin
          if (!f_valid) begin
            err_desc  <= 1'b1;
            err_state <= PH_FETCH;
            ph        <= PH_STOP;
          end else if (shape_bad) begin
            err_desc  <= 1'b1;
            err_state <= PH_ADDR;
            ph        <= PH_STOP;
          end else if (is_move && f_len != '0) begin
            wptr <= f_addr;
            left <= f_len;
            sum  <= sum_nx;
            ph   <= PH_MOVE;
          end else begin
            sum <= sum_nx;
            irq <= f_int;
            if (f_end) begin
              done <= 1'b1;
              ph   <= PH_STOP;
              if (sum_nx != want) begin
                err_len   <= 1'b1;
                err_state <= is_move ? PH_MOVE : PH_ADDR;
              end
            end else begin
              ptr <= is_link ? f_addr : ptr + DSC_STEP;
              ph  <= PH_FETCH;
            end
          end
        end
        PH_MOVE: begin
          if (beat_ack) begin
            wptr <= wptr + BEAT_STEP;
            left <= left - LAST_BEAT;
            if (left == LAST_BEAT) begin
              irq <= f_int;
              if (f_end) begin
                done <= 1'b1;
                ph   <= PH_STOP;
                if (sum != want) begin
                  err_len   <= 1'b1;
                  err_state <= PH_MOVE;
                end
              end else begin
                ptr <= ptr + DSC_STEP;
                ph  <= PH_FETCH;
              end
            end
          end
        end
        default: ph <= PH_STOP;
      endcase
    end
  end

  assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_req && !dsc_ack) |=> (dsc_req && $stable(dsc_addr)));

  assert_beat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_req && !beat_ack) |=> (beat_req && $stable(beat_addr)));

  assert_beat_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_req |-> (beat_addr[1:0] == 2'b00));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_bad_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_desc) |-> (!busy && !done && err_state != 2'd0));

  assert_idle_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy) && !err_len && !err_desc) |-> (err_state == 2'd0));

endmodule

// File: tb/sg_desc_walker_test.sv
module sg_desc_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] table_base = '0;
  logic [31:0] expect_bytes = '0;
  logic        dsc_req, beat_req, busy, done, irq, err_len, err_desc;
  logic [31:0] dsc_addr, beat_addr;
  logic        dsc_ack = 1'b0;
  logic        beat_ack = 1'b0;
  logic [63:0] dsc_data = '0;
  logic [1:0]  err_state;

  sg_desc_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .table_base(table_base),
    .expect_bytes(expect_bytes), .dsc_req(dsc_req), .dsc_addr(dsc_addr),
    .dsc_ack(dsc_ack), .dsc_data(dsc_data), .beat_req(beat_req),
    .beat_addr(beat_addr), .beat_ack(beat_ack), .busy(busy), .done(done),
    .irq(irq), .err_len(err_len), .err_desc(err_desc), .err_state(err_state)
  );

  always #2 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit [63:0] mem [int];
  int fq[$];
  int bq[$];
  int iq[$];
  int ev = 0;
  int done_ev;
  int done_seen;
  bit x_done, x_len, x_desc;
  int x_st;

  task automatic chk(string tag, string what, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit [63:0] mk(int a, int len, bit v, bit e, bit i, bit [1:0] act);
    return {a[31:0], len[15:0], 10'b0, act, 1'b0, i, e, v};
  endfunction

  task automatic model(int base, int expv);
    int p = base;
    int total = 0;
    int k = 0;
    fq.delete(); bq.delete(); iq.delete();
    ev = 0; done_seen = 0;
    x_done = 0; x_len = 0; x_desc = 0; x_st = 0; done_ev = -1;
    while (k < 64) begin
      bit [63:0] d;
      int a, len, act;
      k++;
      fq.push_back(p); ev++;
      d = mem.exists(p) ? mem[p] : 64'd0;
      a = int'(d[63:32]); len = int'(d[31:16]); act = int'(d[5:4]);
      if (!d[0]) begin x_desc = 1; x_st = 1; break; end
      if ((act == 2 && (a % 4 != 0 || len % 4 != 0)) || (act == 3 && a % 4 != 0)) begin
        x_desc = 1; x_st = 2; break;
      end
      if (act == 2) begin
        for (int j = 0; j < len / 4; j++) begin bq.push_back(a + 4 * j); ev++; end
        total += len;
      end
      if (d[2]) iq.push_back(ev);
      if (d[1]) begin
        x_done = 1; done_ev = ev;
        if (total != expv) begin x_len = 1; x_st = (act == 2) ? 3 : 2; end
        break;
      end
      p = (act == 3) ? a : p + 8;
    end
    ev = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (irq) begin
        if (iq.size() == 0) chk("R7", "unexpected irq", 1, 0);
        else chk("R7", "irq after handshakes", ev, iq.pop_front());
      end
      if (done) begin
        done_seen++;
        chk("R6", "done after handshakes", ev, done_ev);
        chk("R6", "busy low with done", busy, 0);
      end
      dsc_ack = 1'b0;
      beat_ack = 1'b0;
      if (dsc_req && ($urandom % 4 != 0)) begin
        dsc_ack = 1'b1;
        dsc_data = mem.exists(int'(dsc_addr)) ? mem[int'(dsc_addr)] : 64'd0;
        if (fq.size() == 0) chk("R2", "unexpected fetch", dsc_addr, 0);
        else chk("R2", "fetch address", dsc_addr, fq.pop_front());
        ev++;
      end
      if (beat_req && ($urandom % 3 != 0)) begin
        beat_ack = 1'b1;
        if (bq.size() == 0) chk("R4", "unexpected beat", beat_addr, 0);
        else chk("R4", "beat address", beat_addr, bq.pop_front());
        ev++;
      end
    end
  end

  task automatic run(string tag, int base, int expv, bit midstart);
    int n = 0;
    model(base, expv);
    @(negedge clk);
    table_base = base; expect_bytes = expv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (midstart) begin
      repeat (6) @(negedge clk);
      chk("R11", "still busy before second start", busy, 1);
      table_base = 32'h700; expect_bytes = 0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy && n < 150000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk(tag, "walk finished", busy, 0);
    chk(tag, "fetch queue drained", fq.size(), 0);
    chk(tag, "beat queue drained", bq.size(), 0);
    chk("R7", "irq queue drained", iq.size(), 0);
    chk("R6", "done count", done_seen, x_done);
    chk("R10", "err_len", err_len, x_len);
    chk(tag, "err_desc", err_desc, x_desc);
    chk(tag, "err_state", err_state, x_st);
  endtask

  initial begin
    mem[32'h100] = mk(0, 0, 1, 0, 1, 2'b00);
    mem[32'h108] = mk(32'h2000, 12, 1, 0, 1, 2'b10);
    mem[32'h110] = mk(32'h9990, 0, 1, 0, 0, 2'b01);
    mem[32'h118] = mk(32'h400, 0, 1, 0, 0, 2'b11);
    mem[32'h400] = mk(32'h3000, 8, 1, 1, 0, 2'b10);
    mem[32'h600] = mk(32'h4000, 8, 1, 1, 1, 2'b10);
    mem[32'h700] = mk(0, 0, 1, 0, 0, 2'b00);
    mem[32'h708] = mk(32'h1234, 4, 0, 1, 1, 2'b10);
    mem[32'h800] = mk(32'h5002, 8, 1, 1, 0, 2'b10);
    mem[32'h880] = mk(32'h5000, 16'hFFFF, 1, 1, 0, 2'b10);
    mem[32'h900] = mk(32'hA02, 0, 1, 0, 0, 2'b11);
    mem[32'h980] = mk(32'h6000, 4, 1, 0, 0, 2'b10);
    mem[32'h988] = mk(0, 0, 1, 1, 0, 2'b00);
    mem[32'hA00] = mk(32'h7000, 0, 1, 1, 1, 2'b10);
    mem[32'hA80] = mk(32'h10000, 16'hFFFC, 1, 1, 0, 2'b10);
    mem[32'hB00] = mk(32'hC00, 0, 1, 1, 0, 2'b11);
    mem[32'hB08] = mk(32'h8000, 4, 1, 1, 0, 2'b10);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "dsc_req", dsc_req, 0);
    chk("R1", "beat_req", beat_req, 0);
    chk("R1", "done", done, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "errors", {err_len, err_desc}, 0);
    chk("R1", "err_state", err_state, 0);

    run("R3", 32'h100, 20, 0);
    run("R10", 32'h600, 16, 0);
    run("R8", 32'h700, 0, 0);
    run("R9", 32'h800, 8, 0);
    run("R9", 32'h880, 0, 0);
    run("R9", 32'h900, 0, 0);
    run("R10", 32'h980, 8, 0);
    run("R12", 32'h100, 20, 1);
    run("R4", 32'hA00, 0, 0);
    run("R5", 32'hB00, 4, 0);
    run("R4", 32'hA80, 32'hFFFC, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule